// File: doc/BRIEF.md
# Nibble Dual-Port RAM with Selectable Write Mode

This block is a small memory of 32 words, each 4 bits wide. It has one write port and one read port, and the two ports work independently of each other. A read needs no clock. The read output is combinational from the read address and the stored words.

A static mode input picks how writes behave. In clocked mode, a write is taken at the rising clock edge. In transparent mode, the incoming data flows straight through to the read side while the write is held open, and it is committed to the array. Both modes write only when load is high and the active-low write enable is low.

A synchronous clear zeroes the whole array. An output enable forces the read output to zero when it is low. A parameter builds a single-port variant, in which the write address also serves as the read address.

Top module: `nib_dpram`

## Requirements
- R1: After reset every word holds 0, so any read address returns 0 while `out_en` is 1.
- R2: `rd_data` follows a change of `rd_addr` within the same cycle, with no clock edge needed.
- R3: With `trans_mode`=0 (clocked mode), a word is written at the rising edge where `load`=1 and `wr_n`=0. Before that edge, a read of the word shows its old value.
- R4: While `load`=0 or `wr_n`=1, no word changes across clock edges.
- R5: A write changes only the word at `wr_addr`. All 32 words keep their own distinct contents.
- R6: With `trans_mode`=1 (transparent mode), while `load`=1 and `wr_n`=0, a read of `wr_addr` shows the current `wr_data` without waiting for an edge. It follows later changes of the data. After the write closes, the last data present at a clock edge is retained.
- R7: `clear`=1 at a rising edge sets every word to 0. It wins over a write in the same cycle and also suppresses the transparent flow-through.
- R8: With `out_en`=0, `rd_data` is 0 whatever the address and contents are.
- R9: With `SINGLE_PORT`=1, reads use `wr_addr` and `rd_addr` has no effect on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset; zeroes the array |
| trans_mode | input | 1 | Static write mode: 1 transparent, 0 clocked |
| load | input | 1 | Write qualifier, active high |
| wr_n | input | 1 | Write enable, active low |
| clear | input | 1 | Synchronous clear of all words |
| wr_addr | input | ADDR_W | Write address (also the read address in single-port builds) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| out_en | input | 1 | Read output enable; output is 0 when low |
| rd_data | output | DATA_W | Read data |

## Verification
The properties assume that `trans_mode` stays static, and that every input changes once per cycle at a point away from the rising edge. Under that assumption the value sampled at an edge is the value that committed there. The bench keeps to these conditions in three ways. It sets the mode only while no write is open. It changes all inputs on the falling edge. It samples combinational reads a short delay after each change, or just before the next rising edge. Transparent writes hold their data stable across at least one rising edge before the write closes, so the retained value is the one the checks expect.

// File: rtl/nram_pkg.sv
package nram_pkg;
    typedef enum logic {
        WM_CLOCKED     = 1'b0,
        WM_TRANSPARENT = 1'b1
    } wmode_e;

    function automatic logic wr_open(input logic load, input logic wr_n);
        return load & ~wr_n;
    endfunction
endpackage

// File: rtl/nram_wr_dec.sv
module nram_wr_dec
    import nram_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              trans_mode,
    input  logic              load,
    input  logic              wr_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [DEPTH-1:0]  word_sel,
    output logic              flow_en
);
    logic   go;
    wmode_e mode;

    assign mode    = wmode_e'(trans_mode);
    assign go      = wr_open(load, wr_n) & ~clear;
    assign flow_en = go & (mode == WM_TRANSPARENT);

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign word_sel[g] = go & (wr_addr == ADDR_W'(g));
    end
endmodule

// File: rtl/nram_rd_path.sv
module nram_rd_path #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         flow_en,
    input  logic                         out_en,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] picked;

    always_comb begin
        if (flow_en && (rd_addr == wr_addr)) begin
            picked = wr_data;
        end else begin
            picked = words[rd_addr];
        end
        rd_data = out_en ? picked : '0;
    end
endmodule

// File: rtl/nib_dpram.sv
module nib_dpram #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 4,
    parameter bit SINGLE_PORT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trans_mode,
    input  logic              load,
    input  logic              wr_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] words;
    } store_t;

    store_t             st_d, st_q;
    logic [DEPTH-1:0]   word_sel;
    logic               flow_en;
    logic [ADDR_W-1:0]  eff_rd_addr;

    if (SINGLE_PORT) begin : g_sp
        assign eff_rd_addr = wr_addr;
    end else begin : g_dp
        assign eff_rd_addr = rd_addr;
    end

    nram_wr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .trans_mode (trans_mode),
        .load       (load),
        .wr_n       (wr_n),
        .clear      (clear),
        .wr_addr    (wr_addr),
        .word_sel   (word_sel),
        .flow_en    (flow_en)
    );

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.words = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (word_sel[i]) begin
                    st_d.words[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    nram_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .words   (st_q.words),
        .rd_addr (eff_rd_addr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flow_en (flow_en),
        .out_en  (out_en),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/nib_dpram_chk.sv
module nib_dpram_chk #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 4,
    parameter bit SINGLE_PORT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trans_mode,
    input logic              load,
    input logic              wr_n,
    input logic              clear,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              out_en,
    input logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] eff;
    logic              wq;

    assign eff = SINGLE_PORT ? wr_addr : rd_addr;
    assign wq  = load & ~wr_n;

    AST_OE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> rd_data == '0); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ((out_en && !(trans_mode && wq && !clear)) -> rd_data == '0)); // R7

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wq && !clear) |=> (($stable(eff) && $stable(out_en) && !wq && !clear)
                             -> $stable(rd_data))); // R4

    AST_EDGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!trans_mode && wq && !clear) |=> ((out_en && eff == $past(wr_addr)
                                            && !(trans_mode && wq))
                                           -> rd_data == $past(wr_data))); // R3

    AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_mode && wq && !clear && out_en && eff == wr_addr)
        |-> rd_data == wr_data); // R6
endmodule

bind nib_dpram nib_dpram_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SINGLE_PORT (SINGLE_PORT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trans_mode (trans_mode),
    .load       (load),
    .wr_n       (wr_n),
    .clear      (clear),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .out_en     (out_en),
    .rd_data    (rd_data)
);

// File: tb/test_nib_dpram.sv
module test_nib_dpram;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trans_mode = 1'b0;
    logic              load = 1'b0;
    logic              wr_n = 1'b1;
    logic              clear = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              out_en = 1'b1;
    logic [DATA_W-1:0] rd_data, rd_data_sp;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    nib_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SINGLE_PORT(1'b0)) i_nib_dpram (
        .clk(clk), .rst_n(rst_n), .trans_mode(trans_mode), .load(load), .wr_n(wr_n),
        .clear(clear), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .out_en(out_en), .rd_data(rd_data)
    );

    nib_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SINGLE_PORT(1'b1)) i_nib_dpram_sp (
        .clk(clk), .rst_n(rst_n), .trans_mode(trans_mode), .load(load), .wr_n(wr_n),
        .clear(clear), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .out_en(out_en), .rd_data(rd_data_sp)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int a);
        return DATA_W'((a * 3 + 1) ^ (a >> 2));
    endfunction

    task automatic read_at(input int a, input string req, input logic [DATA_W-1:0] exp);
        rd_addr = ADDR_W'(a);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic write_clk(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_addr = ADDR_W'(a); wr_data = d; load = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        load = 1'b0; wr_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        read_at(0, "R1", '0);
        read_at(17, "R1", '0);
        read_at(DEPTH-1, "R1", '0);
    endtask

    task automatic t_clocked_write();
        @(negedge clk);
        trans_mode = 1'b0;
        wr_addr = 5'd9; wr_data = 4'hC; load = 1'b1; wr_n = 1'b0;
        read_at(9, "R3 pre-edge", '0);
        @(posedge clk); #1;
        check("R3 post-edge", rd_data, 4'hC);
        @(negedge clk);
        load = 1'b0; wr_n = 1'b1;
    endtask

    task automatic t_async_read();
        write_clk(3, 4'h5);
        write_clk(7, 4'hA);
        read_at(3, "R2", 4'h5);
        read_at(7, "R2", 4'hA);
        read_at(9, "R2", 4'hC);
    endtask

    task automatic t_no_write();
        @(negedge clk);
        wr_addr = 5'd3; wr_data = 4'hF; load = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        load = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        load = 1'b0;
        read_at(3, "R4", 4'h5);
    endtask

    task automatic t_all_words();
        for (int a = 0; a < DEPTH; a++) write_clk(a, pat(a));
        for (int a = 0; a < DEPTH; a++) read_at(a, "R5", pat(a));
    endtask

    task automatic t_transparent();
        @(negedge clk);
        trans_mode = 1'b1;
        @(negedge clk);
        wr_addr = 5'd12; wr_data = 4'h6; load = 1'b1; wr_n = 1'b0;
        read_at(12, "R6 flow", 4'h6);
        wr_data = 4'h9;
        #1;
        check("R6 follow", rd_data, 4'h9);
        @(negedge clk);
        load = 1'b0; wr_n = 1'b1;
        read_at(12, "R6 retain", 4'h9);
        read_at(13, "R6 neighbour", pat(13));
        @(negedge clk);
        trans_mode = 1'b0;
    endtask

    task automatic t_out_enable();
        @(negedge clk);
        out_en = 1'b0;
        read_at(7, "R8", '0);
        read_at(12, "R8", '0);
        out_en = 1'b1;
        read_at(12, "R8 restore", 4'h9);
    endtask

    task automatic t_single_port();
        write_clk(20, 4'hB);
        @(negedge clk);
        wr_addr = 5'd20; rd_addr = 5'd2;
        #1;
        check("R9 uses wr_addr", rd_data_sp, 4'hB);
        rd_addr = 5'd30;
        #1;
        check("R9 rd_addr ignored", rd_data_sp, 4'hB);
    endtask

    task automatic t_clear();
        @(negedge clk);
        trans_mode = 1'b1;
        @(negedge clk);
        wr_addr = 5'd5; wr_data = 4'hE; load = 1'b1; wr_n = 1'b0; clear = 1'b1;
        read_at(5, "R7 no flow", pat(5));
        @(negedge clk);
        clear = 1'b0; load = 1'b0; wr_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) read_at(a, "R7", '0);
        trans_mode = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clocked_write();
        t_async_read();
        t_no_write();
        t_all_words();
        t_transparent();
        t_out_enable();
        t_single_port();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule